// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block owns every refresh of an asynchronous DRAM with an internal refresh row counter. After reset it waits out a power-up pause counted in slow timer ticks. It then issues a burst of column-before-row (CBR) refresh cycles and only afterwards raises its init-done flag. In normal operation it counts ticks from the end of the previous refresh and, when the interval has run out, asks the access controller for the memory pins. While it holds the grant it drives the row and column strobes itself. No address is produced because the device chooses the refresh row.

The host can also park the memory in self refresh with a level request. The sequencer brackets the self-refresh period with ordinary CBR refreshes: one just before entry and one just after exit, both under the same grant. It holds the row strobe low for at least the minimum self-refresh time, then uses the longer self-refresh precharge before the next row strobe. The request/grant pair is a plain control handshake. The controller must not start an access while `ref_req_o` is high, and must keep `ref_gnt_i` high until `ref_req_o` falls. Strobe phases are counted in clock cycles. The power-up pause, the refresh interval and the self-refresh minimum are counted in `tick_i` pulses.

Top module: `dram_refresh_seq`

## Requirements
- R1: After reset the strobes stay inactive until PAUSE_TICKS ticks have been counted. Exactly INIT_REFS CBR cycles then follow, and `init_done_o` rises after the precharge of the last one and stays high until reset.
- R2: After initialisation, `ref_req_o` rises when INTERVAL_TICKS ticks have passed since the row strobe rose at the end of the previous refresh, provided no self-refresh request is pending.
- R3: In every CBR cycle all column strobe bits go low together exactly T_CSR cycles before the row strobe falls, and they stay low for the whole row-low time.
- R4: Write enable and output enable are held high (value 1) at all times, so the data pins stay undriven.
- R5: The row strobe is low for exactly T_RAS cycles in every refresh cycle.
- R6: Between two row-low pulses the row strobe stays high for at least T_RP cycles, and for at least T_RPS cycles after leaving self refresh.
- R7: The strobes are active only while `ref_req_o` and `ref_gnt_i` are both high. `ref_req_o` stays high from the request until the last precharge of the sequence ends, which holds host accesses off.
- R8: A high `sr_req_i` seen while idle after initialisation starts one CBR cycle; self refresh (column then row strobe low, `sr_active_o` = 1) is entered only after it.
- R9: In self refresh the row strobe stays low for at least SR_MIN_TICKS ticks and until `sr_req_i` is low.
- R10: After self-refresh exit, one CBR cycle is issued before `ref_req_o` falls.
- R11: A self-refresh request that is withdrawn before `init_done_o` rises has no effect: no self refresh starts and the initial refresh count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse from the slow time base |
| sr_req_i | input | 1 | Level request to enter and stay in self refresh |
| ref_gnt_i | input | 1 | Memory pins granted by the access controller |
| ref_req_o | output | 1 | Sequencer needs the memory pins; host accesses held off |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | CAS_W | Column strobes (one per byte lane), active low |
| we_n_o | output | 1 | Write enable, held inactive |
| oe_n_o | output | 1 | Output enable, held inactive |
| init_done_o | output | 1 | Power-up sequence complete |
| sr_active_o | output | 1 | Memory is being held in self refresh |

## Verification
A wrong state in the sequencer appears at the ports within one clock cycle as a strobe pattern that breaks the CBR order, or as strobe activity without the grant. A wrong phase count shows as the wrong row-low or column lead length on the next row-strobe edge. A fault in the init counter only appears when `init_done_o` rises, as the wrong number of refreshes before it. A fault in the interval timer appears one interval later, as a request outside its tick window. Self-refresh faults surface at exit, as a short hold or a precharge that is too short, and when the request drops, as a missing post-exit refresh.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [3:0] {
    ST_PAUSE,
    ST_IDLE,
    ST_WAITG,
    ST_CSR,
    ST_RASLO,
    ST_PRE,
    ST_SR_CSR,
    ST_SR_HOLD,
    ST_SR_PRE
  } seq_st_t;

  // purpose of the CBR cycle in progress
  typedef enum logic [1:0] {
    K_INIT,
    K_NORM,
    K_SR_IN,
    K_SR_OUT
  } cbr_kind_t;

endpackage

// File: rtl/rfsh_tick_cnt.sv
module rfsh_tick_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         done_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (tick_i && cnt_q < limit_i) cnt_q <= cnt_q + W'(1);
  end

  assign done_o = (cnt_q >= limit_i);

  AST_TICK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clr_i && !done_o) |=> (cnt_q == $past(cnt_q) + W'(1))); // R2

endmodule

// File: rtl/rfsh_phase_cnt.sv
module rfsh_phase_cnt #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);

  AST_PHASE_PARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o); // R5

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_rfsh_pkg::*;
#(
  parameter int CAS_W          = 2,
  parameter int TICK_W         = 16,
  parameter int PAUSE_TICKS    = 101,
  parameter int INTERVAL_TICKS = 15,
  parameter int SR_MIN_TICKS   = 101,
  parameter int INIT_REFS      = 8,
  parameter int T_CSR          = 3,
  parameter int T_RAS          = 20,
  parameter int T_RP           = 15,
  parameter int T_RPS          = 38
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             sr_req_i,
  input  logic             ref_gnt_i,
  output logic             ref_req_o,
  output logic             ras_n_o,
  output logic [CAS_W-1:0] cas_n_o,
  output logic             we_n_o,
  output logic             oe_n_o,
  output logic             init_done_o,
  output logic             sr_active_o
);

  localparam int PH_W = $clog2(T_CSR + T_RAS + T_RP + T_RPS + 1);
  localparam int IR_W = $clog2(INIT_REFS + 1);
  localparam logic [PH_W-1:0] PH_CSR = PH_W'(T_CSR - 1);
  localparam logic [PH_W-1:0] PH_RAS = PH_W'(T_RAS - 1);
  localparam logic [PH_W-1:0] PH_RP  = PH_W'(T_RP - 1);
  localparam logic [PH_W-1:0] PH_RPS = PH_W'(T_RPS - 1);
  localparam logic [IR_W-1:0] LAST_INIT = IR_W'(INIT_REFS - 1);

  seq_st_t   st_q, st_d;
  cbr_kind_t kind_q, kind_d;
  logic [IR_W-1:0] icnt_q, icnt_d;
  logic idone_q, idone_d;

  logic            ph_load, ph_zero;
  logic [PH_W-1:0] ph_val;
  logic            long_clr, long_done, iv_clr, iv_done;
  logic [TICK_W-1:0] long_limit;

  // long window: power-up pause, then self-refresh minimum hold
  assign long_clr   = (st_q == ST_SR_CSR);
  assign long_limit = idone_q ? TICK_W'(SR_MIN_TICKS) : TICK_W'(PAUSE_TICKS);

  rfsh_tick_cnt #(.W(TICK_W)) u_long (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (long_clr),
    .tick_i  (tick_i),
    .limit_i (long_limit),
    .done_o  (long_done)
  );

  // refresh interval, restarted by every row-low pulse
  assign iv_clr = st_q inside {ST_PAUSE, ST_RASLO, ST_SR_CSR, ST_SR_HOLD, ST_SR_PRE};

  rfsh_tick_cnt #(.W(TICK_W)) u_intv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (iv_clr),
    .tick_i  (tick_i),
    .limit_i (TICK_W'(INTERVAL_TICKS)),
    .done_o  (iv_done)
  );

  rfsh_phase_cnt #(.W(PH_W)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ph_load),
    .load_val_i (ph_val),
    .zero_o     (ph_zero)
  );

  always_comb begin
    st_d    = st_q;
    kind_d  = kind_q;
    icnt_d  = icnt_q;
    idone_d = idone_q;
    ph_load = 1'b0;
    ph_val  = '0;
    unique case (st_q)
      ST_PAUSE: if (long_done) begin
        st_d   = ST_WAITG;
        kind_d = K_INIT;
      end
      ST_IDLE: begin
        if (sr_req_i) begin
          st_d   = ST_WAITG;
          kind_d = K_SR_IN;
        end else if (iv_done) begin
          st_d   = ST_WAITG;
          kind_d = K_NORM;
        end
      end
      ST_WAITG: if (ref_gnt_i) begin
        st_d = ST_CSR; ph_load = 1'b1; ph_val = PH_CSR;
      end
      ST_CSR: if (ph_zero) begin
        st_d = ST_RASLO; ph_load = 1'b1; ph_val = PH_RAS;
      end
      ST_RASLO: if (ph_zero) begin
        st_d = ST_PRE; ph_load = 1'b1; ph_val = PH_RP;
      end
      ST_PRE: if (ph_zero) begin
        unique case (kind_q)
          K_INIT: begin
            if (icnt_q == LAST_INIT) begin
              st_d    = ST_IDLE;
              idone_d = 1'b1;
            end else begin
              icnt_d = icnt_q + IR_W'(1);
              st_d = ST_CSR; ph_load = 1'b1; ph_val = PH_CSR;
            end
          end
          K_SR_IN: begin
            st_d = ST_SR_CSR; ph_load = 1'b1; ph_val = PH_CSR;
          end
          default: st_d = ST_IDLE;
        endcase
      end
      ST_SR_CSR: if (ph_zero) st_d = ST_SR_HOLD;
      ST_SR_HOLD: if (long_done && !sr_req_i) begin
        st_d = ST_SR_PRE; ph_load = 1'b1; ph_val = PH_RPS;
      end
      ST_SR_PRE: if (ph_zero) begin
        st_d = ST_CSR; kind_d = K_SR_OUT; ph_load = 1'b1; ph_val = PH_CSR;
      end
      default: st_d = ST_PAUSE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      st_q    <= ST_PAUSE;
      kind_q  <= K_INIT;
      icnt_q  <= '0;
      idone_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      kind_q  <= kind_d;
      icnt_q  <= icnt_d;
      idone_q <= idone_d;
    end
  end

  logic cas_lo;
  assign cas_lo      = st_q inside {ST_CSR, ST_RASLO, ST_SR_CSR, ST_SR_HOLD};
  assign ras_n_o     = !(st_q inside {ST_RASLO, ST_SR_HOLD});
  assign cas_n_o     = {CAS_W{!cas_lo}};
  assign ref_req_o   = !(st_q inside {ST_PAUSE, ST_IDLE});
  assign sr_active_o = (st_q == ST_SR_HOLD);
  assign init_done_o = idone_q;
  assign we_n_o      = 1'b1;
  assign oe_n_o      = 1'b1;

  // checker counter: length of a non-self-refresh row-low pulse
  logic [PH_W-1:0] ras_lo_cnt;
  always_ff @(posedge clk_i) begin
    if (!rst_ni)                               ras_lo_cnt <= '0;
    else if (!ras_n_o && st_q != ST_SR_HOLD)   ras_lo_cnt <= ras_lo_cnt + PH_W'(1);
    else                                       ras_lo_cnt <= '0;
  end

  AST_CAS_LEADS_RAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (cas_n_o == '0 && $past(cas_n_o) == '0)); // R3
  AST_CAS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n_o |-> (cas_n_o == '0)); // R3
  AST_PINS_GRANTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o || cas_n_o != '1) |-> (ref_req_o && ref_gnt_i)); // R7
  AST_INIT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o); // R1
  AST_RAS_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o && st_q != ST_SR_HOLD) |-> (ras_lo_cnt < PH_W'(T_RAS))); // R5
  AST_SR_AFTER_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_active_o |-> init_done_o); // R11
  AST_SR_MIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sr_active_o) && ras_n_o) |-> $past(long_done)); // R9

endmodule

// File: tb/sim_dram_refresh_seq.sv
`timescale 1ns/1ps
module sim_dram_refresh_seq;

  localparam int D     = 4;   // clocks per tick
  localparam int PAUSE = 20;
  localparam int IV    = 30;
  localparam int SRMIN = 25;
  localparam int NINIT = 8;
  localparam int TCSR  = 3;
  localparam int TRAS  = 5;
  localparam int TRP   = 4;
  localparam int TRPS  = 7;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, sr_req = 1'b0, gnt = 1'b0;
  logic ref_req, ras_n, we_n, oe_n, init_done, sr_active;
  logic [1:0] cas_n;

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dram_refresh_seq #(
    .CAS_W(2), .TICK_W(16), .PAUSE_TICKS(PAUSE), .INTERVAL_TICKS(IV),
    .SR_MIN_TICKS(SRMIN), .INIT_REFS(NINIT), .T_CSR(TCSR), .T_RAS(TRAS),
    .T_RP(TRP), .T_RPS(TRPS)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sr_req_i(sr_req),
    .ref_gnt_i(gnt), .ref_req_o(ref_req), .ras_n_o(ras_n), .cas_n_o(cas_n),
    .we_n_o(we_n), .oe_n_o(oe_n), .init_done_o(init_done), .sr_active_o(sr_active)
  );

  function automatic int need_pre(bit after_sr);
    return after_sr ? TRPS : TRP;
  endfunction
  function automatic int iv_lo();  return (IV - 1) * D + 1; endfunction
  function automatic int iv_hi();  return IV * D + 1;       endfunction
  function automatic int sr_min(); return (SRMIN - 1) * D;  endfunction
  function automatic int pause_min(); return (PAUSE - 1) * D; endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // tick source
  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      tick = (tc == D - 1);
      tc = (tc + 1) % D;
    end
  end

  // access controller: random grant latency, releases when request drops
  initial begin
    int wl = 0;
    forever begin
      @(negedge clk);
      if (!ref_req) gnt = 1'b0;
      else if (!gnt) begin
        if (wl == 0) begin gnt = 1'b1; wl = $urandom_range(0, 3); end
        else wl--;
      end
    end
  end

  // port monitor
  initial begin
    int cyc = 0, cas_run = 0, lo_run = 0, hi_run = 1000, init_refs = 0;
    int last_rise = 0, cbr_in_grant = 0;
    bit p_ras = 1, p_req = 0, p_sr = 0, p_init = 0, first_fall = 1;
    bit after_sr = 0, in_sr = 0, iv_armed = 0, sr_in_grant = 0, post_done = 0;
    forever begin
      @(negedge clk); #1;
      if (rst_n) begin
        cyc++;
        chk(we_n && oe_n, "R4 we/oe", {we_n, oe_n}, 3);
        chk((ras_n && cas_n == 2'b11) || (ref_req && gnt), "R7 strobe without grant",
            {ras_n, cas_n}, 7);
        if (!ras_n) chk(cas_n == 2'b00, "R3 cas held", cas_n, 0);
        if (sr_active) in_sr = 1;
        if (p_ras && !ras_n) begin
          chk(cas_run == TCSR, "R3 cas lead", cas_run, TCSR);
          chk(hi_run >= need_pre(after_sr), after_sr ? "R6 sr precharge" : "R6 precharge",
              hi_run, need_pre(after_sr));
          if (first_fall) begin
            chk(cyc >= pause_min(), "R1 pause", cyc, pause_min());
            first_fall = 0;
          end
          after_sr = 0;
        end
        if (!p_ras && ras_n) begin
          if (in_sr) begin
            chk(lo_run >= sr_min(), "R9 sr hold", lo_run, sr_min());
            chk(!sr_req, "R9 exit with request low", sr_req, 0);
            after_sr = 1; in_sr = 0; post_done = 0;
          end else begin
            chk(lo_run == TRAS, "R5 row low", lo_run, TRAS);
            if (!init_done) init_refs++;
            cbr_in_grant++;
            if (sr_in_grant) post_done = 1;
          end
          last_rise = cyc;
          iv_armed = !sr_req;
        end
        if (!p_req && ref_req) begin
          if (init_done && !sr_req && iv_armed)
            chk(cyc - last_rise >= iv_lo() && cyc - last_rise <= iv_hi(),
                "R2 interval", cyc - last_rise, iv_hi());
          cbr_in_grant = 0; sr_in_grant = 0;
        end
        if (!p_sr && sr_active) begin
          chk(cbr_in_grant >= 1, "R8 pre-entry refresh", cbr_in_grant, 1);
          chk(init_done, "R11 sr before init", init_done, 1);
          sr_in_grant = 1; post_done = 0;
        end
        if (p_req && !ref_req && sr_in_grant)
          chk(post_done, "R10 post-exit refresh", post_done, 1);
        if (!p_init && init_done)
          chk(init_refs == NINIT, "R1 init refresh count", init_refs, NINIT);
        cas_run = (cas_n == 2'b00) ? cas_run + 1 : 0;
        lo_run  = !ras_n ? lo_run + 1 : 0;
        hi_run  = ras_n ? hi_run + 1 : 0;
        p_ras = ras_n; p_req = ref_req; p_sr = sr_active; p_init = init_done;
      end
    end
  end

  task automatic do_sr(input int hold);
    @(negedge clk);
    sr_req = 1'b1;
    wait (sr_active);
    @(negedge clk);
    repeat (hold) @(negedge clk);
    sr_req = 1'b0;
    wait (!ref_req);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    #1;
    chk(!ref_req, "R7 reset request", ref_req, 0);
    chk(ras_n && cas_n == 2'b11, "R1 reset strobes", {ras_n, cas_n}, 7);
    chk(!init_done, "R1 reset init_done", init_done, 0);
    chk(!sr_active, "R11 reset sr_active", sr_active, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R11: request raised and withdrawn inside the power-up pause
    repeat (10) @(negedge clk);
    sr_req = 1'b1;
    repeat (30) @(negedge clk);
    sr_req = 1'b0;
    wait (init_done);
    repeat (400) @(negedge clk);
    do_sr(2);          // R9: released well before the minimum
    repeat (300) @(negedge clk);
    do_sr(SRMIN * D);  // R9: held past the minimum
    for (int i = 0; i < 5; i++) begin
      repeat ($urandom_range(20, 300)) @(negedge clk);
      do_sr($urandom_range(0, 250));
    end
    repeat (500) @(negedge clk);
    finished = 1;
    finish_run();
  end

  initial begin
    repeat (100000) @(negedge clk);
    if (!finished) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
      finish_run();
    end
  end

endmodule